// File: doc/BRIEF.md
# I2C Master Event Flag Register

This block holds the sticky event flags of an I2C master controller and presents them as one 8-bit status register on a simple processor bus with read and write strobes. The bit engine, the arbitration detector and the rest of the register file stay outside the block. They reach it only as one-cycle event strobes: a NACK seen in an acknowledge slot, arbitration lost, a STOP driven on the bus, a forced-stop request and four further master events. A strobe sets its flag, and the flag then holds until software writes 0 to that bit.

When arbitration is lost, the block also drops the master interface enable that it owns. The enable stays low until software writes it back to 1. Before the STOP-transmitted flag can be set, a STOP must have been requested either by software forcing a stop or by a NACK received in a data phase. The flags, each gated by its own interrupt enable, are ORed into one level interrupt.

Top module: `mflag_status`

## Requirements
- R1: Bit 7 always reads 0 and writes to it have no effect. Bit 6 is NACK received, bit 5 is arbitration lost, bit 4 is STOP transmitted, and bits 3..0 are the further events `ev_aux[3:0]`, with bit n taken from `ev_aux[n]`.
- R2: After reset every flag is 0, `irq_o` is 0 and `men_o` is 1 (the default of `MEN_RESET`).
- R3: A set flag stays at 1 through idle cycles. Writing 1 to its bit position leaves it unchanged.
- R4: A write with 0 in a flag's bit position clears that flag on the next clock edge and leaves flags written with 1 unchanged.
- R5: If a set strobe and a write of 0 reach the same flag in the same cycle, the flag is 1 after that edge.
- R6: A pulse on `ev_ack_nack` sets the NACK flag, whether `ev_data_phase` marks a data byte or an address byte.
- R7: A pulse on `ev_arb_lost` sets the arbitration flag and drives `men_o` to 0 on the same edge. This overrides a software write of the enable in that same cycle.
- R8: Once arbitration loss has cleared `men_o`, it stays 0 until `men_wr` is pulsed with `men_wdata` = 1. Clearing the arbitration flag does not restore it.
- R9: A pulse on `ev_stop_sent` sets the STOP flag only if a STOP request is pending or arrives in the same cycle. A request comes from an `ev_force_stop` pulse or from an `ev_ack_nack` pulse with `ev_data_phase` = 1. Each STOP consumes the pending request, and an unrequested STOP leaves the flag at 0.
- R10: `irq_o` is the OR over all flags of each flag ANDed with its `irq_en` bit. With `IRQ_REG` = 0 it follows `irq_en` and the flags in the same cycle as a level.
- R11: `rd_data` shows the current flags in the same cycle that `rd_en` is high, and is all zeros while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; a 0 clears the flag at that position |
| rd_data | output | 8 | Read data, combinational |
| irq_en | input | 7 | Per-flag interrupt enables, bit-aligned with the flags |
| men_wr | input | 1 | Software write strobe for the master enable |
| men_wdata | input | 1 | Value written to the master enable |
| men_o | output | 1 | Master interface enable |
| ev_ack_nack | input | 1 | SDA sampled high in an acknowledge slot |
| ev_data_phase | input | 1 | The acknowledge slot follows a data byte (1) or an address byte (0) |
| ev_force_stop | input | 1 | Software forced-stop request |
| ev_stop_sent | input | 1 | STOP condition completed on the bus |
| ev_arb_lost | input | 1 | Arbitration lost to another master |
| ev_aux | input | 4 | Further master event strobes |
| irq_o | output | 1 | Level interrupt request |

## Verification
On every cycle, the assertions check that flags are sticky, that a clearing write takes effect, that a set strobe beats a clearing write, that arbitration loss forces and holds the enable low, and that a STOP flag only ever rises after a STOP strobe. Some behaviours can only be shown by the bench's directed scenarios. These are the bit layout seen through reads, the rejection of an unrequested STOP after an address NACK, the consuming of a pending request, interrupt gating as the enables change, and the zero read data while no read is strobed.

// File: rtl/mflag_pkg.sv
package mflag_pkg;
   // Hardware-sourced flags, offset above the auxiliary event bits.
   // The order fixes the register layout: NACK highest, then ARB, then STOP.
   typedef enum int {
      SRC_STOP = 0,
      SRC_ARB  = 1,
      SRC_NACK = 2
   } mflag_src_e;

   localparam int NUM_HW_SRC = 3;
endpackage

// File: rtl/mflag_bit.sv
module mflag_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   // R3: a flag without a clear request holds at 1
   p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o && !clr_i) |=> q_o);
   // R4: a clear without a set empties the flag
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
   // R5: a set always lands, even against a clear
   p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
endmodule

// File: rtl/mflag_stop_qual.sv
module mflag_stop_qual (
   input  logic clk,
   input  logic rst_n,
   input  logic force_stop_i,
   input  logic nack_i,
   input  logic data_phase_i,
   input  logic stop_sent_i,
   output logic stop_set_o
);
   logic req_now;
   logic pend_q;

   assign req_now    = force_stop_i | (nack_i & data_phase_i);
   assign stop_set_o = stop_sent_i & (pend_q | req_now);

   always_ff @(posedge clk) begin
      if (!rst_n)           pend_q <= 1'b0;
      else if (stop_sent_i) pend_q <= 1'b0;
      else if (req_now)     pend_q <= 1'b1;
   end

   // R9: a completed STOP always consumes the pending request
   p_consume_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_sent_i |=> !pend_q);
endmodule

// File: rtl/mflag_irq.sv
module mflag_irq #(
   parameter int NFLAG = 7
) (
   input  logic [NFLAG-1:0] flags_i,
   input  logic [NFLAG-1:0] en_i,
   output logic             req_o
);
   logic [NFLAG-1:0] gated;

   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_gate
         assign gated[i] = flags_i[i] & en_i[i];
      end
   endgenerate

   assign req_o = |gated;
endmodule

// File: rtl/mflag_status.sv
module mflag_status
   import mflag_pkg::*;
#(
   parameter int  DW        = 8,
   parameter int  NUM_AUX   = 4,
   parameter bit  MEN_RESET = 1'b1,
   parameter bit  IRQ_REG   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic               wr_en,
   input  logic [DW-1:0]      wr_data,
   output logic [DW-1:0]      rd_data,
   input  logic [NUM_AUX+2:0] irq_en,
   input  logic               men_wr,
   input  logic               men_wdata,
   output logic               men_o,
   input  logic               ev_ack_nack,
   input  logic               ev_data_phase,
   input  logic               ev_force_stop,
   input  logic               ev_stop_sent,
   input  logic               ev_arb_lost,
   input  logic [NUM_AUX-1:0] ev_aux,
   output logic               irq_o
);
   localparam int NFLAG    = NUM_AUX + NUM_HW_SRC;
   localparam int NRSV     = DW - NFLAG;
   localparam int IDX_STOP = NUM_AUX + SRC_STOP;
   localparam int IDX_ARB  = NUM_AUX + SRC_ARB;
   localparam int IDX_NACK = NUM_AUX + SRC_NACK;

   generate
      if (NRSV < 1) begin : g_bad_width
         $error("mflag_status: DW must exceed the flag count");
      end
      if (NUM_AUX < 1) begin : g_bad_aux
         $error("mflag_status: NUM_AUX must be at least 1");
      end
   endgenerate

   logic [NFLAG-1:0] set_v;
   logic [NFLAG-1:0] clr_v;
   logic [NFLAG-1:0] flags;
   logic             stop_set;
   logic             irq_raw;

   // ---------------- STOP source qualification
   mflag_stop_qual u_stop (
      .clk          (clk),
      .rst_n        (rst_n),
      .force_stop_i (ev_force_stop),
      .nack_i       (ev_ack_nack),
      .data_phase_i (ev_data_phase),
      .stop_sent_i  (ev_stop_sent),
      .stop_set_o   (stop_set)
   );

   // ---------------- set / clear vectors
   always_comb begin
      set_v                = '0;
      set_v[NUM_AUX-1:0]   = ev_aux;
      set_v[IDX_STOP]      = stop_set;
      set_v[IDX_ARB]       = ev_arb_lost;
      set_v[IDX_NACK]      = ev_ack_nack;
   end

   assign clr_v = {NFLAG{wr_en}} & ~wr_data[NFLAG-1:0];

   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_flag
         mflag_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[i]),
            .clr_i (clr_v[i]),
            .q_o   (flags[i])
         );
      end
   endgenerate

   // ---------------- read path (reserved bits fixed at 0)
   assign rd_data = rd_en ? {{NRSV{1'b0}}, flags} : '0;

   // ---------------- master enable
   always_ff @(posedge clk) begin
      if (!rst_n)           men_o <= MEN_RESET;
      else if (ev_arb_lost) men_o <= 1'b0;
      else if (men_wr)      men_o <= men_wdata;
   end

   // ---------------- interrupt
   mflag_irq #(.NFLAG(NFLAG)) u_irq (
      .flags_i (flags),
      .en_i    (irq_en),
      .req_o   (irq_raw)
   );

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= irq_raw;
         end
      end else begin : g_irq_comb
         assign irq_o = irq_raw;
      end
   endgenerate

   // R7: arbitration loss drops the enable at the next edge
   p_arb_men_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_arb_lost |=> !men_o);
   // R8: a dropped enable stays low until software writes 1
   p_men_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!men_o && !(men_wr && men_wdata)) |=> !men_o);
   // R9: the STOP flag only rises on the edge after a STOP strobe
   p_stop_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[IDX_STOP] && !ev_stop_sent) |=> !flags[IDX_STOP]);
   // R6: a NACK strobe always leaves the NACK flag set
   p_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ack_nack |=> flags[IDX_NACK]);
endmodule

// File: tb/test_mflag_status.sv
module test_mflag_status;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_en = 0, wr_en = 0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [6:0] irq_en = '0;
   logic       men_wr = 0, men_wdata = 0, men_o;
   logic       ev_ack_nack = 0, ev_data_phase = 0, ev_force_stop = 0;
   logic       ev_stop_sent = 0, ev_arb_lost = 0;
   logic [3:0] ev_aux = '0;
   logic       irq_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #5 clk = ~clk;

   mflag_status i_mflag_status (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq_en(irq_en),
      .men_wr(men_wr), .men_wdata(men_wdata), .men_o(men_o),
      .ev_ack_nack(ev_ack_nack), .ev_data_phase(ev_data_phase),
      .ev_force_stop(ev_force_stop), .ev_stop_sent(ev_stop_sent),
      .ev_arb_lost(ev_arb_lost), .ev_aux(ev_aux), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(output logic [7:0] v);
      rd_en = 1'b1; #1; v = rd_data; rd_en = 1'b0;
   endtask

   task automatic wr(input logic [7:0] v);
      wr_en = 1'b1; wr_data = v; step(); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic clear_all();
      wr(8'h00);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(v);
      chk("R2 flags after reset", v, 8'h00);
      chk("R2 men after reset", {7'b0, men_o}, 8'h01);
      chk("R2 irq after reset", {7'b0, irq_o}, 8'h00);
   endtask

   task automatic t_nack_layout();
      logic [7:0] v;
      ev_ack_nack = 1; ev_data_phase = 0; step(); ev_ack_nack = 0;
      rd(v); chk("R6 address NACK sets bit 6", v, 8'h40);
      ev_aux = 4'b1000; step(); ev_aux = 4'b0001; step(); ev_aux = '0;
      rd(v); chk("R1 aux bits 3 and 0", v, 8'h49);
      clear_all();
   endtask

   task automatic t_write_one();
      logic [7:0] v;
      ev_aux = 4'b0001; ev_ack_nack = 1; step(); ev_aux = '0; ev_ack_nack = 0;
      wr(8'hFF);
      rd(v); chk("R3 write of ones keeps flags", v, 8'h41);
      chk("R1 reserved bit reads 0", {7'b0, v[7]}, 8'h00);
      wr(8'hBF);
      rd(v); chk("R4 write 0 to bit 6 clears only it", v, 8'h01);
      step(3);
      rd(v); chk("R3 flag holds through idle", v, 8'h01);
      rd_en = 1'b0; #1;
      chk("R11 rd_data zero without strobe", rd_data, 8'h00);
      clear_all();
   endtask

   task automatic t_race();
      logic [7:0] v;
      ev_aux = 4'b0001; step(); ev_aux = '0;
      ev_aux = 4'b0010; wr_en = 1; wr_data = 8'h00; step();
      ev_aux = '0; wr_en = 0;
      rd(v); chk("R5 set beats same-cycle clear", v, 8'h02);
      clear_all();
   endtask

   task automatic t_arb();
      logic [7:0] v;
      ev_arb_lost = 1; men_wr = 1; men_wdata = 1; step();
      ev_arb_lost = 0; men_wr = 0; men_wdata = 0;
      rd(v); chk("R7 arbitration flag bit 5", v, 8'h20);
      chk("R7 men dropped over write", {7'b0, men_o}, 8'h00);
      wr(8'hDF); step(3);
      rd(v); chk("R8 arb flag cleared", v, 8'h00);
      chk("R8 men stays low", {7'b0, men_o}, 8'h00);
      men_wr = 1; men_wdata = 1; step(); men_wr = 0; men_wdata = 0;
      chk("R8 men restored by write", {7'b0, men_o}, 8'h01);
   endtask

   task automatic t_stop();
      logic [7:0] v;
      ev_force_stop = 1; step(); ev_force_stop = 0; step(2);
      ev_stop_sent = 1; step(); ev_stop_sent = 0;
      rd(v); chk("R9 forced STOP sets bit 4", v, 8'h10);
      clear_all();
      ev_stop_sent = 1; step(); ev_stop_sent = 0;
      rd(v); chk("R9 request consumed, second STOP ignored", v, 8'h00);
      ev_ack_nack = 1; ev_data_phase = 1; ev_stop_sent = 1; step();
      ev_ack_nack = 0; ev_data_phase = 0; ev_stop_sent = 0;
      rd(v); chk("R9 data NACK same-cycle STOP", v, 8'h50);
      clear_all();
      ev_ack_nack = 1; step(); ev_ack_nack = 0; step();
      ev_stop_sent = 1; step(); ev_stop_sent = 0;
      rd(v); chk("R9 address NACK does not qualify STOP", v, 8'h40);
      clear_all();
   endtask

   task automatic t_irq();
      ev_aux = 4'b0100; step(); ev_aux = '0;
      irq_en = '0; #1;
      chk("R10 irq off when disabled", {7'b0, irq_o}, 8'h00);
      irq_en = 7'b0000100; #1;
      chk("R10 irq follows enable same cycle", {7'b0, irq_o}, 8'h01);
      irq_en = 7'b1111011; #1;
      chk("R10 other enables do not fire", {7'b0, irq_o}, 8'h00);
      irq_en = 7'b1111111;
      clear_all(); #1;
      chk("R10 irq drops with flag", {7'b0, irq_o}, 8'h00);
      irq_en = '0;
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step();
      t_reset();
      t_nack_layout();
      t_write_one();
      t_race();
      t_arb();
      t_stop();
      t_irq();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule